// File: doc/BRIEF.md
# Serial-Controlled Open-Drain Port Expander Core

This block is an I2C target that controls eight open-drain port bits. A controller addresses it with a 7-bit address. The upper three bits of that address are fixed at `110`. The lower four bits arrive on `addr_lo` from an external strap decoder. After a write address, every data byte the controller sends is loaded into the port latch. After a read address, the block returns two bytes in turn and keeps repeating them: first the synchronized pin levels, then the sticky per-pin change flags. It stops when the controller answers a byte with NACK.

The change flags compare each synchronized pin against a snapshot. That snapshot is taken each time the flag byte finishes shifting out, and it is all ones after power-on. The active-low `int_n` output is the OR of the flags. The `xfer_rst_n` input aborts only the serial engine. It leaves the flags, the snapshot, the interrupt and the port latch as they are. `por_n` is the power-on reset for the whole core.

SCL and SDA are sampled on `clk` through synchronizers. The block drives the bus only through the `sda_pull` enable. The serial interface has no valid/ready stream: the bus pins themselves pace every transfer, and the block never stretches the clock.

Top module: `pxp_core`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `110` followed by `addr_lo[3:0]`; bit 0 is read (1) or write (0). With any other address it gives no ACK and ignores the rest of the transfer.
- R2: In a write transfer, each data byte after the address is acknowledged and loaded into `port_q`; bit n of the byte drives port n, so the last byte written wins.
- R3: `port_pd[n]` is high exactly when `port_q[n]` is 0. At power-on `port_q` is all ones, so no pin is pulled.
- R4: The first byte of a read transfer is the synchronized `port_in` value, MSB first, with bit n taken from port n.
- R5: The second read byte is the change-flag byte. Further bytes alternate between the input byte and the flag byte for as long as the controller ACKs.
- R6: Flag n sets, and stays set, when synchronized pin n differs from the snapshot. Once the flag byte has shifted out, all flags clear and the snapshot takes the current pin levels. The snapshot is all ones after power-on.
- R7: `int_n` is low exactly while any flag is set. It rises only after a flag byte has been read during a transfer.
- R8: Holding `xfer_rst_n` low immediately returns the serial engine to idle and releases SDA. It does not change `int_n`, the flags or `port_q`, and the next transfer proceeds normally.
- R9: `standby` is high whenever the engine has no active transfer: after reset, after STOP, after an address mismatch and after a read NACK. It is low from START until that point.
- R10: A START seen during a transfer (repeated START) restarts address reception.
- R11: A NACK from the controller after a read byte ends the read; the block releases SDA and loads no further byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears everything |
| xfer_rst_n | input | 1 | Asynchronous transfer abort, active low, serial engine only |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level |
| sda_pull | output | 1 | Pull SDA low when high |
| addr_lo | input | 4 | Low four address bits from the strap decoder |
| port_in | input | 8 | Pin levels of the eight ports |
| port_q | output | 8 | Port output latch |
| port_pd | output | 8 | Per-pin open-drain pull-down enable |
| int_n | output | 1 | Interrupt, active low, any change flag set |
| standby | output | 1 | High while the serial interface is idle |

## Verification
The hardest case to reach from the ports is an abort that lands while the block itself holds SDA low during the address acknowledge and an interrupt is pending. The stimulus sets up this case in order. First it raises a flag by changing a pin. Then it clocks a matching address by hand and stops with SCL high in the ACK slot. It pulses `xfer_rst_n` there. It then clocks the remainder of a data byte, which the idle engine must ignore, before a fresh transfer proves the engine recovered. Address matching is swept over all sixteen strap values, both with a correct address and with two wrong ones.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  localparam logic [2:0] ADDR_HI = 3'b110;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDAT,
    S_WACK,
    S_RDAT,
    S_RACK
  } xfer_state_t;
endpackage

// File: rtl/pxp_sync.sv
module pxp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else if (s == 0) pipe[s] <= d;
      else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pxp_edge.sv
module pxp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_ev  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/pxp_flags.sv
module pxp_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         clr,
  output logic [W-1:0] flags,
  output logic         int_n
);
  logic [W-1:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap  <= '1;
      flags <= '0;
    end else if (clr) begin
      snap  <= lvl;
      flags <= '0;
    end else begin
      flags <= flags | (lvl ^ snap);
    end
  end

  assign int_n = ~|flags;
endmodule

// File: rtl/pxp_engine.sv
module pxp_engine
  import pxp_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_bit,
  input  logic [AW-1:0] addr_lo,
  input  logic [W-1:0]  rd_inputs,
  input  logic [W-1:0]  rd_flags,
  output logic          sda_pull,
  output logic          idle,
  output logic          wr_valid,
  output logic [W-1:0]  wr_data,
  output logic          flag_sent
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  xfer_state_t st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sr, tx;
  logic          rnw, sel, nack;
  logic [W-1:0]  nxt;

  assign nxt = sel ? rd_inputs : rd_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      rnw       <= 1'b0;
      sel       <= 1'b0;
      nack      <= 1'b0;
      sda_pull  <= 1'b0;
      wr_valid  <= 1'b0;
      flag_sent <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      flag_sent <= 1'b0;
      if (start_ev) begin
        st       <= S_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sr  <= {sr[W-2:0], sda_bit};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (sr[W-1:1] == {ADDR_HI, addr_lo}) begin
                st       <= S_AACK;
                sda_pull <= 1'b1;
                rnw      <= sr[0];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              if (rnw) begin
                tx       <= {rd_inputs[W-2:0], 1'b0};
                sda_pull <= ~rd_inputs[W-1];
                sel      <= 1'b0;
                cnt      <= CW'(1);
                st       <= S_RDAT;
              end else begin
                sda_pull <= 1'b0;
                cnt      <= '0;
                st       <= S_WDAT;
              end
            end
          end
          S_WDAT: begin
            if (scl_rise) begin
              sr  <= {sr[W-2:0], sda_bit};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              wr_valid <= 1'b1;
              sda_pull <= 1'b1;
              cnt      <= '0;
              st       <= S_WACK;
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              st       <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_pull  <= 1'b0;
                flag_sent <= sel == 1'b0 ? 1'b0 : 1'b1;
                st        <= S_RACK;
              end else begin
                sda_pull <= ~tx[W-1];
                tx       <= {tx[W-2:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              nack <= sda_bit;
            end else if (scl_fall) begin
              if (nack) begin
                st <= S_IDLE;
              end else begin
                tx       <= {nxt[W-2:0], 1'b0};
                sda_pull <= ~nxt[W-1];
                sel      <= ~sel;
                cnt      <= CW'(1);
                st       <= S_RDAT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign idle    = (st == S_IDLE);
  assign wr_data = sr;
endmodule

// File: rtl/pxp_core.sv
module pxp_core #(
  parameter int PORT_W = 8,
  parameter int ADDR_LO_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 xfer_rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_pull,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  input  logic [PORT_W-1:0]    port_in,
  output logic [PORT_W-1:0]    port_q,
  output logic [PORT_W-1:0]    port_pd,
  output logic                 int_n,
  output logic                 standby
);
  logic eng_rst_n;
  logic [1:0] bus_s;
  logic [PORT_W-1:0] lvl, flags, wr_data;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_valid, flag_sent;

  assign eng_rst_n = por_n & xfer_rst_n;

  pxp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(por_n), .d({scl_in, sda_in}), .q(bus_s)
  );

  pxp_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL({PORT_W{1'b1}})) u_pin_sync (
    .clk(clk), .rst_n(por_n), .d(port_in), .q(lvl)
  );

  pxp_edge u_edge (
    .clk(clk), .rst_n(eng_rst_n), .scl(bus_s[1]), .sda(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  pxp_engine #(.W(PORT_W), .AW(ADDR_LO_W)) u_engine (
    .clk(clk), .rst_n(eng_rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(bus_s[0]),
    .addr_lo(addr_lo), .rd_inputs(lvl), .rd_flags(flags),
    .sda_pull(sda_pull), .idle(standby),
    .wr_valid(wr_valid), .wr_data(wr_data), .flag_sent(flag_sent)
  );

  pxp_flags #(.W(PORT_W)) u_flags (
    .clk(clk), .rst_n(por_n), .lvl(lvl), .clr(flag_sent),
    .flags(flags), .int_n(int_n)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) port_q <= '1;
    else if (wr_valid) port_q <= wr_data;
  end

  assign port_pd = ~port_q;
endmodule

// File: rtl/pxp_core_chk.sv
module pxp_core_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              xfer_rst_n,
  input logic              sda_pull,
  input logic              standby,
  input logic              int_n,
  input logic [PORT_W-1:0] port_q
);
  // R8
  abort_keeps_irq_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!int_n && !xfer_rst_n) |=> !int_n);

  // R8
  abort_idles_chk: assert property (@(posedge clk) disable iff (!por_n)
    !xfer_rst_n |-> (standby && !sda_pull));

  // R9
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!por_n)
    standby |-> !sda_pull);

  // R2
  latch_in_xfer_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(port_q) |-> !$past(standby));

  // R7
  irq_release_in_xfer_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(int_n) |-> !$past(standby));
endmodule

bind pxp_core pxp_core_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .por_n(por_n), .xfer_rst_n(xfer_rst_n), .sda_pull(sda_pull),
  .standby(standby), .int_n(int_n), .port_q(port_q)
);

// File: tb/sim_pxp_core.sv
`timescale 1ns/1ps
module sim_pxp_core;
  localparam int H = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, xfer_rst_n = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] addr_lo = 4'd0;
  logic [7:0] ext = 8'hFF;
  logic sda_pull, int_n, standby;
  logic [7:0] port_q, port_pd;
  wire sda_line = sda_m & ~sda_pull;
  wire [7:0] pin_lvl = ext & ~port_pd;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] latch_m = 8'hFF, snap_m = 8'hFF, flags_m = 8'h00;

  always #2.5 clk = ~clk;

  pxp_core u0 (
    .clk(clk), .por_n(por_n), .xfer_rst_n(xfer_rst_n),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .addr_lo(addr_lo), .port_in(pin_lvl), .port_q(port_q),
    .port_pd(port_pd), .int_n(int_n), .standby(standby)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic void model_pins();
    flags_m |= ((ext & latch_m) ^ snap_m);
  endfunction

  function automatic void model_flag_read();
    snap_m  = ext & latch_m;
    flags_m = 8'h00;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; cyc(H);
    scl_m = 1'b1; cyc(H);
    sda_m = 1'b0; cyc(H);
    scl_m = 1'b0; cyc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(H);
    scl_m = 1'b1; cyc(H);
    sda_m = 1'b1; cyc(H);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(H);
      scl_m = 1'b1; cyc(H);
      scl_m = 1'b0;
    end
    cyc(H);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    send_bits(b);
    sda_m = 1'b1; cyc(H);
    scl_m = 1'b1; cyc(H/2);
    ack = !sda_line;
    cyc(H - H/2);
    scl_m = 1'b0; cyc(H);
  endtask

  task automatic read_byte(input bit do_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(H);
      scl_m = 1'b1; cyc(H/2);
      b[i] = sda_line;
      cyc(H - H/2);
      scl_m = 1'b0;
    end
    cyc(H);
    sda_m = !do_ack; cyc(H);
    scl_m = 1'b1; cyc(H);
    scl_m = 1'b0; cyc(H);
    sda_m = 1'b1;
  endtask

  task automatic write_port(input logic [7:0] d);
    bit a;
    bus_start();
    write_byte({3'b110, addr_lo, 1'b0}, a);
    write_byte(d, a);
    bus_stop();
    latch_m = d;
    model_pins();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    cyc(4);
    por_n = 1'b1;
    cyc(6);
    // reset state: R3, R7, R9
    chk(port_q == 8'hFF && port_pd == 8'h00, "R3 reset latch", port_q, 8'hFF);
    chk(int_n == 1'b1, "R7 reset irq", int_n, 1);
    chk(standby == 1'b1 && sda_pull == 1'b0, "R9 reset standby", {standby, sda_pull}, 2'b10);

    // R1 sweep over all straps, wrong and right addresses
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      addr_lo = 4'(k);
      d = 8'((k * 29 + 3) & 8'hFF);
      bus_start();
      write_byte({3'b110, 4'(k) ^ 4'b0101, 1'b0}, a);
      chk(!a, "R1 wrong low bits nack", a, 0);
      cyc(2);
      chk(standby, "R9 standby after mismatch", standby, 1);
      write_byte(~d, a);
      bus_stop();
      chk(port_q == latch_m, "R1 wrong addr ignored", port_q, latch_m);
      bus_start();
      write_byte({3'b010, 4'(k), 1'b0}, a);
      chk(!a, "R1 wrong high bits nack", a, 0);
      write_byte(~d, a);
      bus_stop();
      chk(port_q == latch_m, "R1 wrong high ignored", port_q, latch_m);
      bus_start();
      write_byte({3'b110, 4'(k), 1'b0}, a);
      chk(a, "R1 match ack", a, 1);
      chk(!standby, "R9 busy in transfer", standby, 0);
      write_byte(d, a);
      chk(a, "R2 data ack", a, 1);
      bus_stop();
      chk(standby, "R9 standby after stop", standby, 1);
      latch_m = d;
      model_pins();
      chk(port_q == d, "R2 latch value", port_q, d);
      chk(port_pd == ~d, "R3 pull-down map", port_pd, ~d);
    end

    // R2 multi-byte write, walking bit positions
    addr_lo = 4'd9;
    bus_start();
    write_byte({3'b110, 4'd9, 1'b0}, a);
    for (int i = 0; i < 8; i++) begin
      write_byte(8'(1 << i), a);
      chk(a && port_q == 8'(1 << i), "R2 walking byte", port_q, 8'(1 << i));
      latch_m = 8'(1 << i);
      model_pins();
    end
    bus_stop();

    // R3 pulled pins read low: latch 0F, R4 input byte
    write_port(8'h0F);
    bus_start();
    write_byte({3'b110, 4'd9, 1'b1}, a);
    read_byte(1'b0, b);
    bus_stop();
    chk(b == (ext & 8'h0F), "R3 pulled pins read low", b, ext & 8'h0F);

    write_port(8'hFF);
    // clear pending flags with a two-byte read
    bus_start();
    write_byte({3'b110, 4'd9, 1'b1}, a);
    read_byte(1'b1, b);
    read_byte(1'b0, b);
    bus_stop();
    chk(b == flags_m, "R5 flag byte", b, flags_m);
    model_flag_read();
    cyc(4);
    chk(int_n == 1'b1, "R7 irq released", int_n, 1);

    // R4/R5/R6/R7 sweep of pin patterns
    for (int i = 0; i < 14; i++) begin
      ext = (i == 12) ? 8'h00 : (i == 13) ? 8'hFF : 8'((i * 37 + 5) & 8'hFF);
      model_pins();
      cyc(8);
      chk(int_n == (flags_m == 8'h00), "R7 irq follows flags", int_n, flags_m == 8'h00);
      bus_start();
      write_byte({3'b110, 4'd9, 1'b1}, a);
      read_byte(1'b1, b);
      chk(b == (ext & latch_m), "R4 input byte", b, ext & latch_m);
      read_byte(1'b1, b);
      chk(b == flags_m, "R6 flag byte", b, flags_m);
      model_flag_read();
      read_byte(1'b0, b);
      chk(b == (ext & latch_m), "R5 wrap to inputs", b, ext & latch_m);
      cyc(3);
      chk(!sda_pull && standby, "R11 nack releases", {sda_pull, standby}, 2'b01);
      bus_stop();
      chk(int_n == 1'b1, "R7 cleared after flag read", int_n, 1);
    end

    // R6 unchanged pins give empty flags
    bus_start();
    write_byte({3'b110, 4'd9, 1'b1}, a);
    read_byte(1'b1, b);
    read_byte(1'b0, b);
    bus_stop();
    chk(b == 8'h00, "R6 no change no flag", b, 0);

    // R7 input-only read keeps irq low
    ext = 8'h5A; model_pins(); cyc(8);
    bus_start();
    write_byte({3'b110, 4'd9, 1'b1}, a);
    read_byte(1'b0, b);
    bus_stop();
    chk(int_n == 1'b0, "R7 irq held without flag read", int_n, 0);

    // R8 abort during address acknowledge with irq pending
    bus_start();
    send_bits({3'b110, 4'd9, 1'b0});
    sda_m = 1'b1; cyc(H);
    scl_m = 1'b1; cyc(H/2);
    chk(sda_pull == 1'b1, "R1 ack drive before abort", sda_pull, 1);
    xfer_rst_n = 1'b0; cyc(2);
    chk(!sda_pull && standby, "R8 abort idles", {sda_pull, standby}, 2'b01);
    chk(int_n == 1'b0, "R8 irq kept", int_n, 0);
    xfer_rst_n = 1'b1; cyc(H);
    scl_m = 1'b0; cyc(H);
    write_byte(8'h00, a);
    chk(!a, "R8 bytes after abort ignored", a, 0);
    bus_stop();
    chk(port_q == latch_m, "R8 latch kept", port_q, latch_m);
    chk(int_n == 1'b0, "R8 irq still pending", int_n, 0);
    bus_start();
    write_byte({3'b110, 4'd9, 1'b1}, a);
    chk(a, "R8 recovers", a, 1);
    read_byte(1'b1, b);
    read_byte(1'b0, b);
    bus_stop();
    chk(b == flags_m, "R8 flags kept", b, flags_m);
    model_flag_read();

    // R10 repeated start switches to read
    bus_start();
    write_byte({3'b110, 4'd9, 1'b0}, a);
    bus_start();
    write_byte({3'b110, 4'd9, 1'b1}, a);
    chk(a, "R10 restart ack", a, 1);
    read_byte(1'b0, b);
    bus_stop();
    chk(b == (ext & latch_m), "R10 restart read", b, ext & latch_m);
    chk(port_q == latch_m, "R10 no stray write", port_q, latch_m);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule